// File: doc/BRIEF.md
# Masked Packed Half-Precision Multiplier

This block multiplies two packed vectors of IEEE binary16 numbers element by element. The active vector length is 128, 256 or 512 bits, which gives 8, 16 or 32 lanes. Each lane is written under a per-lane write mask. A lane whose mask bit is clear either keeps its previous destination contents or is forced to zero. The second operand can instead supply a single element, element 0, which is then applied to every lane. All destination bits above the active length are cleared.

Every product is correctly rounded in one of four rounding modes. Subnormal results use gradual underflow. Infinities, zeros and NaNs follow fixed rules, and five exception conditions are collected into sticky flags. The result is registered. It appears together with an output valid in the cycle after the input strobe.

Top module: `fp16_vmul`

## Requirements
- R1: `vl_sel` selects the active lane count: 00 gives 8 lanes, 01 gives 16, 10 gives 32, and the reserved code 11 behaves as 00. Lane i occupies bits [16i+15:16i] of every vector port.
- R2: Every destination bit above the active length, up to bit 511, is zero after each operation.
- R3: An active lane is written with `src_a` lane × `src_b` lane when `mask_en` is 0 or its `mask` bit is 1.
- R4: An active lane is written with zero when `mask_en` is 1, its mask bit is 0 and `zero_en` is 1.
- R5: An active lane takes the matching `dst_old` lane when `mask_en` is 1, its mask bit is 0 and `zero_en` is 0.
- R6: When `b_is_mem` and `bcst_rc` are both 1, every written lane uses `src_b` bits [15:0] as its second factor.
- R7: The rounding mode is `rc_embed` when `vl_sel` is 10, `b_is_mem` is 0 and `bcst_rc` is 1. In every other case it is `rc_global`. The codes are 00 nearest-even, 01 toward −∞, 10 toward +∞ and 11 toward zero.
- R8: Products of finite nonzero operands are rounded exactly in the selected mode, and results below the normal range are subnormal (gradual underflow).
- R9: When a rounded magnitude exceeds 0x7BFF, the result depends on the mode. Nearest-even gives ±∞, toward zero gives ±0x7BFF, toward −∞ gives +0x7BFF or −∞, and toward +∞ gives +∞ or −0x7BFF. Overflow and inexact are raised.
- R10: A NaN operand is returned with bit 9 set, and `src_a` wins when both are NaN. A signalling NaN raises invalid. ∞ × 0 gives 0x7E00 and raises invalid. ∞ × nonzero gives a signed ∞, and 0 × finite gives a signed zero.
- R11: The bits of `exc_flags` are [4] invalid, [3] denormal operand (a subnormal operand with no NaN operand), [2] overflow, [1] underflow (tiny before rounding and inexact) and [0] inexact. They OR in the flags of written lanes only. They change only on an input strobe, never clear except on reset, and are zero after reset.
- R12: `out_valid` is high exactly in the cycle after `in_valid`. `dst` is updated in that cycle and holds otherwise. Reset clears `dst` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| vl_sel | input | 2 | Active vector length code |
| src_a | input | 512 | First factor vector |
| src_b | input | 512 | Second factor vector (element 0 used when broadcasting) |
| dst_old | input | 512 | Prior destination contents for merging |
| mask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | Apply the write mask |
| zero_en | input | 1 | Zero masked-off lanes instead of merging |
| b_is_mem | input | 1 | Second factor arrives as a memory operand |
| bcst_rc | input | 1 | Broadcast (memory form) or rounding override (register form) |
| rc_embed | input | 2 | Override rounding mode |
| rc_global | input | 2 | Global rounding mode |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | Registered destination vector |
| exc_flags | output | 5 | Sticky exception flags |

## Verification
The assertions assume that `in_valid` is a plain strobe. They also assume that every control input seen at a strobe is the value that the registered result reflects, so their `$past` samples of `vl_sel`, `mask` and `dst_old` are meaningful only in cycles where `out_valid` is high. The stimulus drives all inputs on the falling edge and holds them through the capturing rising edge. It pulses reset between arithmetic operations, so that each flag check sees only one operation's contributions. It also runs one back-to-back sequence without reset to exercise accumulation.

// File: rtl/fp16m_pkg.sv
`timescale 1ns/1ps
package fp16m_pkg;

    localparam int HW      = 16;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int LZ_W    = $clog2(PROD_W + 1);
    localparam int ESUM_W  = EXP_W + 2;
    localparam int EXC_W   = 5;

    localparam logic [HW-1:0] QNAN_DEFAULT = 16'h7E00;
    localparam logic [HW-2:0] MAG_MAX      = 15'h7BFF;
    localparam logic [HW-2:0] MAG_INF      = 15'h7C00;
    localparam logic [HW-1:0] QUIET_BIT    = 16'h0200;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        VL_128 = 2'b00,
        VL_256 = 2'b01,
        VL_512 = 2'b10,
        VL_RSV = 2'b11
    } vlen_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic invalid;
        logic denorm;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp16_t;

    typedef struct packed {
        logic is_zero;
        logic is_sub;
        logic is_inf;
        logic is_nan;
        logic is_snan;
    } fp16_cls_t;

    function automatic fp16_cls_t classify(input fp16_t v);
        fp16_cls_t c;
        logic exp_max;
        logic exp_min;
        logic frac_nz;
        exp_max   = (v.exp == '1);
        exp_min   = (v.exp == '0);
        frac_nz   = (v.frac != '0);
        c.is_zero = exp_min && !frac_nz;
        c.is_sub  = exp_min && frac_nz;
        c.is_inf  = exp_max && !frac_nz;
        c.is_nan  = exp_max && frac_nz;
        c.is_snan = exp_max && frac_nz && !v.frac[FRAC_W-1];
        return c;
    endfunction

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [PROD_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            found;
        n     = '0;
        found = 1'b0;
        for (int i = PROD_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (v[i]) found = 1'b1;
                else      n = n + LZ_W'(1);
            end
        end
        return n;
    endfunction

    function automatic logic [HW-1:0] overflow_value(input logic sign, input rmode_e rm);
        logic to_inf;
        case (rm)
            RM_NEAR: to_inf = 1'b1;
            RM_DOWN: to_inf = sign;
            RM_UP:   to_inf = !sign;
            default: to_inf = 1'b0;
        endcase
        return {sign, (to_inf ? MAG_INF : MAG_MAX)};
    endfunction

endpackage

// File: rtl/fp16m_round.sv
`timescale 1ns/1ps
module fp16m_round
    import fp16m_pkg::*;
(
    input  logic              sign,
    input  logic [ESUM_W-1:0] exp_sum,
    input  logic [PROD_W-1:0] prod,
    input  rmode_e            rm,
    output logic [HW-1:0]     res,
    output logic              ovf,
    output logic              unf,
    output logic              inx
);
    localparam int WIDE_W = PROD_W + 12;
    localparam int SH_W   = $clog2(WIDE_W + 1);
    localparam int ER_W   = 10;

    logic [LZ_W-1:0]       lz;
    logic [PROD_W-1:0]     norm;
    logic signed [ER_W-1:0] er;
    logic [SH_W-1:0]       sh;
    logic [WIDE_W-1:0]     wide;
    logic [WIDE_W-1:0]     shifted;
    logic [WIDE_W-1:0]     back;
    logic                  lost;
    logic [FRAC_W-1:0]     frac;
    logic                  guard;
    logic                  sticky;
    logic                  inc;
    logic [EXP_W-1:0]      exp_field;
    logic [HW-2:0]         mag;

    assign lz   = lead_zeros(prod);
    assign norm = prod << lz;
    // biased exponent of the normalised product before rounding
    assign er   = $signed({3'b000, exp_sum}) - 10'sd14 - $signed({5'b00000, lz});

    always_comb begin
        if (er > 10'sd0)
            sh = '0;
        else if (er < -10'sd32)
            sh = SH_W'(WIDE_W);
        else
            sh = SH_W'(10'sd1 - er);
    end

    assign wide    = {norm, 12'b0};
    assign shifted = wide >> sh;
    assign back    = shifted << sh;
    assign lost    = (back != wide);

    assign frac   = shifted[WIDE_W-2 -: FRAC_W];
    assign guard  = shifted[WIDE_W-2-FRAC_W];
    assign sticky = (|shifted[WIDE_W-3-FRAC_W:0]) | lost;

    always_comb begin
        case (rm)
            RM_NEAR: inc = guard & (sticky | frac[0]);
            RM_DOWN: inc = (guard | sticky) & sign;
            RM_UP:   inc = (guard | sticky) & !sign;
            default: inc = 1'b0;
        endcase
    end

    // hidden bit still in place means no denormalising shift happened
    assign exp_field = shifted[WIDE_W-1] ? er[EXP_W-1:0] : '0;
    assign mag       = {exp_field, frac} + (HW-1)'(inc);

    assign ovf = (er > 10'sd30) || (mag[HW-2 -: EXP_W] == '1);
    assign inx = guard | sticky | ovf;
    assign unf = (er <= 10'sd0) && (guard | sticky);
    assign res = ovf ? overflow_value(sign, rm) : {sign, mag};

endmodule

// File: rtl/fp16m_lane.sv
`timescale 1ns/1ps
module fp16m_lane
    import fp16m_pkg::*;
(
    input  logic [HW-1:0] a_in,
    input  logic [HW-1:0] b_in,
    input  rmode_e        rm,
    output logic [HW-1:0] res,
    output exc_t          exc
);
    fp16_t              fa;
    fp16_t              fb;
    fp16_cls_t          ca;
    fp16_cls_t          cb;
    logic               sign;
    logic [SIG_W-1:0]   sig_a;
    logic [SIG_W-1:0]   sig_b;
    logic [EXP_W-1:0]   ex_a;
    logic [EXP_W-1:0]   ex_b;
    logic [PROD_W-1:0]  prod;
    logic [ESUM_W-1:0]  exp_sum;
    logic [HW-1:0]      r_res;
    logic               r_ovf;
    logic               r_unf;
    logic               r_inx;
    logic               any_nan;
    logic               inf_zero;
    logic               any_sub;

    assign fa   = a_in;
    assign fb   = b_in;
    assign ca   = classify(fa);
    assign cb   = classify(fb);
    assign sign = fa.sign ^ fb.sign;

    assign sig_a   = {(fa.exp != '0), fa.frac};
    assign sig_b   = {(fb.exp != '0), fb.frac};
    assign ex_a    = (fa.exp == '0) ? EXP_W'(1) : fa.exp;
    assign ex_b    = (fb.exp == '0) ? EXP_W'(1) : fb.exp;
    assign prod    = PROD_W'(sig_a) * PROD_W'(sig_b);
    assign exp_sum = ESUM_W'(ex_a) + ESUM_W'(ex_b);

    fp16m_round u_round (
        .sign    (sign),
        .exp_sum (exp_sum),
        .prod    (prod),
        .rm      (rm),
        .res     (r_res),
        .ovf     (r_ovf),
        .unf     (r_unf),
        .inx     (r_inx)
    );

    assign any_nan  = ca.is_nan | cb.is_nan;
    assign inf_zero = (ca.is_inf & cb.is_zero) | (ca.is_zero & cb.is_inf);
    assign any_sub  = ca.is_sub | cb.is_sub;

    always_comb begin
        exc = '0;
        if (any_nan) begin
            res         = ca.is_nan ? (a_in | QUIET_BIT) : (b_in | QUIET_BIT);
            exc.invalid = ca.is_snan | cb.is_snan;
        end else if (inf_zero) begin
            res         = QNAN_DEFAULT;
            exc.invalid = 1'b1;
            exc.denorm  = any_sub;
        end else if (ca.is_inf | cb.is_inf) begin
            res        = {sign, MAG_INF};
            exc.denorm = any_sub;
        end else if (ca.is_zero | cb.is_zero) begin
            res        = {sign, 15'b0};
            exc.denorm = any_sub;
        end else begin
            res           = r_res;
            exc.denorm    = any_sub;
            exc.overflow  = r_ovf;
            exc.underflow = r_unf;
            exc.inexact   = r_inx;
        end
    end

endmodule

// File: rtl/fp16m_ctrl.sv
`timescale 1ns/1ps
module fp16m_ctrl
    import fp16m_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [1:0]       vl_sel,
    input  logic [LANES-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_en,
    input  logic             b_is_mem,
    input  logic             bcst_rc,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_global,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_keep,
    output rmode_e           rm,
    output logic             bcast
);
    localparam int BASE_LANES = 8;

    int   span;
    logic act;

    always_comb begin
        case (vlen_e'(vl_sel))
            VL_256:  span = BASE_LANES * 2;
            VL_512:  span = BASE_LANES * 4;
            default: span = BASE_LANES;
        endcase
        if (span > LANES) span = LANES;
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            act          = (i < span);
            lane_wr[i]   = act && (!mask_en || mask[i]);
            lane_keep[i] = act && mask_en && !mask[i] && !zero_en;
        end
    end

    assign bcast = b_is_mem && bcst_rc;
    assign rm    = (vlen_e'(vl_sel) == VL_512 && !b_is_mem && bcst_rc)
                   ? rmode_e'(rc_embed) : rmode_e'(rc_global);

endmodule

// File: rtl/fp16_vmul.sv
`timescale 1ns/1ps
module fp16_vmul
    import fp16m_pkg::*;
#(
    parameter int MAX_W = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         vl_sel,
    input  logic [MAX_W-1:0]   src_a,
    input  logic [MAX_W-1:0]   src_b,
    input  logic [MAX_W-1:0]   dst_old,
    input  logic [MAX_W/HW-1:0] mask,
    input  logic               mask_en,
    input  logic               zero_en,
    input  logic               b_is_mem,
    input  logic               bcst_rc,
    input  logic [1:0]         rc_embed,
    input  logic [1:0]         rc_global,
    output logic               out_valid,
    output logic [MAX_W-1:0]   dst,
    output logic [EXC_W-1:0]   exc_flags
);
    localparam int LANES = MAX_W / HW;

    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_keep;
    rmode_e           rm;
    logic             bcast;
    logic [MAX_W-1:0] next_dst;
    exc_t             lane_exc [LANES];
    exc_t             op_exc;
    exc_t             exc_q;

    fp16m_ctrl #(.LANES(LANES)) u_ctrl (
        .vl_sel    (vl_sel),
        .mask      (mask),
        .mask_en   (mask_en),
        .zero_en   (zero_en),
        .b_is_mem  (b_is_mem),
        .bcst_rc   (bcst_rc),
        .rc_embed  (rc_embed),
        .rc_global (rc_global),
        .lane_wr   (lane_wr),
        .lane_keep (lane_keep),
        .rm        (rm),
        .bcast     (bcast)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [HW-1:0] b_sel;
        logic [HW-1:0] prod_res;

        assign b_sel = bcast ? src_b[HW-1:0] : src_b[g*HW +: HW];

        fp16m_lane u_lane (
            .a_in (src_a[g*HW +: HW]),
            .b_in (b_sel),
            .rm   (rm),
            .res  (prod_res),
            .exc  (lane_exc[g])
        );

        assign next_dst[g*HW +: HW] = lane_wr[g]   ? prod_res :
                                      lane_keep[g] ? dst_old[g*HW +: HW] :
                                                     '0;
    end

    always_comb begin
        op_exc = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_wr[i]) op_exc = op_exc | lane_exc[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst       <= '0;
            exc_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst   <= next_dst;
                exc_q <= exc_q | op_exc;
            end
        end
    end

    assign exc_flags = exc_q;

endmodule

// File: rtl/fp16_vmul_checker.sv
`timescale 1ns/1ps
module fp16_vmul_checker #(
    parameter int MAX_W = 512
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       vl_sel,
    input logic             mask0,
    input logic             mask_en,
    input logic             zero_en,
    input logic [15:0]      dst_old_l0,
    input logic             out_valid,
    input logic [MAX_W-1:0] dst,
    input logic [4:0]       exc_flags
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                              // R12
    AST_VALID_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                            // R12
    AST_DST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(dst));                                          // R12
    AST_UPPER_CLEAR_128: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(vl_sel) == 2'b00) |-> (dst[MAX_W-1:128] == '0));  // R2
    AST_UPPER_CLEAR_256: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(vl_sel) == 2'b01) |-> (dst[MAX_W-1:256] == '0));  // R2
    AST_ZEROED_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_en && !mask0) |=> (dst[15:0] == 16'h0)); // R4
    AST_MERGED_LANE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_en && !mask0) |=> (dst[15:0] == $past(dst_old_l0))); // R5
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));      // R11
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(exc_flags));                                    // R11
endmodule

bind fp16_vmul fp16_vmul_checker #(.MAX_W(MAX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .vl_sel     (vl_sel),
    .mask0      (mask[0]),
    .mask_en    (mask_en),
    .zero_en    (zero_en),
    .dst_old_l0 (dst_old[15:0]),
    .out_valid  (out_valid),
    .dst        (dst),
    .exc_flags  (exc_flags)
);

// File: tb/fp16_vmul_bench.sv
`timescale 1ns/1ps
module fp16_vmul_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   vl_sel = '0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] dst_old = '0;
    logic [31:0]  mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_en = 1'b0;
    logic         b_is_mem = 1'b0;
    logic         bcst_rc = 1'b0;
    logic [1:0]   rc_embed = '0;
    logic [1:0]   rc_global = '0;
    logic         out_valid;
    logic [511:0] dst;
    logic [4:0]   exc_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    fp16_vmul u_fp16_vmul (
        .clk, .rst, .in_valid, .vl_sel, .src_a, .src_b, .dst_old, .mask,
        .mask_en, .zero_en, .b_is_mem, .bcst_rc, .rc_embed, .rc_global,
        .out_valid, .dst, .exc_flags
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Reference product: returns {invalid,denorm,overflow,underflow,inexact, result}
    function automatic logic [20:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                            input logic [1:0] rm);
        int ea, eb, fa, fb, n, er, sh;
        bit an, bn, snan, dn, sgn, tiny, inexact, up;
        longint sa, sb, xa, xb, p, x, m, rem, half;
        logic [4:0]  fl;
        logic [15:0] r;
        ea = int'(a[14:10]); eb = int'(b[14:10]);
        fa = int'(a[9:0]);   fb = int'(b[9:0]);
        an = (ea == 31) && (fa != 0);
        bn = (eb == 31) && (fb != 0);
        snan = (an && !a[9]) || (bn && !b[9]);
        dn = (ea == 0 && fa != 0) || (eb == 0 && fb != 0);
        sgn = a[15] ^ b[15];
        if (an || bn) return {snan, 4'b0, (an ? (a | 16'h0200) : (b | 16'h0200))};
        if ((ea == 31 && b[14:0] == 0) || (a[14:0] == 0 && eb == 31))
            return {1'b1, dn, 3'b0, 16'h7E00};
        if (ea == 31 || eb == 31) return {1'b0, dn, 3'b0, sgn, 15'h7C00};
        if (a[14:0] == 0 || b[14:0] == 0) return {1'b0, dn, 3'b0, sgn, 15'h0};
        sa = longint'((ea != 0 ? 1024 : 0) + fa);
        sb = longint'((eb != 0 ? 1024 : 0) + fb);
        xa = longint'((ea == 0 ? 1 : ea) - 25);
        xb = longint'((eb == 0 ? 1 : eb) - 25);
        p = sa * sb;
        x = xa + xb;
        n = 0;
        while ((p >> n) != 0) n++;
        er = n - 1 + int'(x) + 15;
        tiny = (er < 1);
        if (er < 1) er = 1;
        sh = er - 25 - int'(x);
        if (sh <= 0) begin
            m = p << (-sh); rem = 0; half = 1;
        end else if (sh > 50) begin
            m = 0; rem = 1; half = 2;
        end else begin
            m = p >> sh; rem = p - (m << sh); half = longint'(1) << (sh - 1);
        end
        inexact = (rem != 0);
        case (rm)
            2'b00:   up = (rem > half) || (rem == half && inexact && m[0]);
            2'b01:   up = inexact && sgn;
            2'b10:   up = inexact && !sgn;
            default: up = 0;
        endcase
        if (up) m = m + 1;
        if (m == 2048) begin m = 1024; er = er + 1; end
        fl = {1'b0, dn, 1'b0, tiny && inexact, inexact};
        if (er >= 31) begin
            fl[2] = 1; fl[0] = 1;
            case (rm)
                2'b00:   r = {sgn, 15'h7C00};
                2'b01:   r = sgn ? 16'hFC00 : 16'h7BFF;
                2'b10:   r = sgn ? 16'hFBFF : 16'h7C00;
                default: r = {sgn, 15'h7BFF};
            endcase
        end else if (m >= 1024) begin
            r = {sgn, er[4:0], 10'(m - 1024)};
        end else begin
            r = {sgn, 5'd0, 10'(m)};
        end
        return {fl, r};
    endfunction

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // inputs already set; strobe once and sample after the capturing edge
    task automatic strobe();
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R12", "out_valid after strobe", 32'(out_valid), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // full expected-value comparison of the current input set
    task automatic run_and_check(input bit do_reset, input logic [4:0] prior_flags);
        int nl;
        bit bc, wr, act;
        logic [1:0]  rmu;
        logic [15:0] bl, ex;
        logic [20:0] rr;
        logic [4:0]  fl;
        string tag;
        nl  = (vl_sel == 2'b01) ? 16 : (vl_sel == 2'b10) ? 32 : 8;
        bc  = b_is_mem && bcst_rc;
        rmu = (vl_sel == 2'b10 && !b_is_mem && bcst_rc) ? rc_embed : rc_global;
        if (do_reset) pulse_reset();
        strobe();
        fl = prior_flags;
        for (int l = 0; l < 32; l++) begin
            act = (l < nl);
            wr  = act && (!mask_en || mask[l]);
            bl  = bc ? src_b[15:0] : src_b[16*l +: 16];
            rr  = ref_mul(src_a[16*l +: 16], bl, rmu);
            if (!act) begin
                ex = 16'h0; tag = "R2";
            end else if (wr) begin
                ex = rr[15:0]; fl = fl | rr[20:16];
                if (rr[20] || src_a[16*l+10 +: 5] == 5'h1F || bl[14:10] == 5'h1F) tag = "R10";
                else if (rr[18]) tag = "R9";
                else if (bc) tag = "R6";
                else if (vl_sel == 2'b10 && bcst_rc) tag = "R7";
                else if (l >= 8) tag = "R1";
                else if (mask_en) tag = "R3";
                else tag = "R8";
            end else if (zero_en) begin
                ex = 16'h0; tag = "R4";
            end else begin
                ex = dst_old[16*l +: 16]; tag = "R5";
            end
            check(tag, $sformatf("lane %0d of %h*%h rm%0d", l, src_a[16*l +: 16], bl, rmu),
                  32'(dst[16*l +: 16]), 32'(ex));
        end
        check("R11", "exception flags", 32'(exc_flags), 32'(fl));
    endtask

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    logic [15:0] vals [26] = '{
        16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h03FF, 16'h0200, 16'h0400,
        16'h3C00, 16'hBC00, 16'h3C01, 16'h3555, 16'h4000, 16'hC200, 16'h7BFF,
        16'hFBFF, 16'h7C00, 16'hFC00, 16'h7E00, 16'h7D00, 16'hFE01, 16'h5BFF,
        16'h2000, 16'h0801, 16'h1400, 16'h3800, 16'h7800
    };

    initial begin : main
        int k;
        logic [511:0] hold;
        // reset state
        repeat (2) @(negedge clk);
        #1;
        check("R12", "out_valid in reset", 32'(out_valid), 32'd0);
        check("R12", "dst in reset", 32'(dst[31:0] | dst[511:480]), 32'd0);
        check("R11", "flags in reset", 32'(exc_flags), 32'd0);
        rst = 1'b0;

        // exhaustive pairs of special values in all rounding modes, 8 lanes per op
        for (int rm = 0; rm < 4; rm++) begin
            k = 0;
            src_a = '0; src_b = '0;
            for (int i = 0; i < 26; i++) begin
                for (int j = 0; j < 26; j++) begin
                    src_a[16*k +: 16] = vals[i];
                    src_b[16*k +: 16] = vals[j];
                    k++;
                    if (k == 8 || (i == 25 && j == 25)) begin
                        vl_sel = 2'b00; mask_en = 0; zero_en = 0; b_is_mem = 0;
                        bcst_rc = 0; rc_global = 2'(rm); rc_embed = 2'(3 - rm);
                        dst_old = rand512();
                        run_and_check(1, 5'b0);
                        k = 0; src_a = '0; src_b = '0;
                    end
                end
            end
        end

        // random operands, unmasked, random global mode
        for (int t = 0; t < 1500; t++) begin
            src_a = rand512(); src_b = rand512(); dst_old = rand512();
            vl_sel = 2'b00; mask_en = 0; zero_en = 0; b_is_mem = 0; bcst_rc = 0;
            rc_global = 2'($urandom); rc_embed = 2'($urandom);
            run_and_check(1, 5'b0);
        end

        // masking, zeroing, broadcast, lengths and rounding selection
        for (int t = 0; t < 800; t++) begin
            src_a = rand512(); src_b = rand512(); dst_old = rand512();
            vl_sel = 2'($urandom); mask = $urandom;
            mask_en = 1'($urandom); zero_en = 1'($urandom);
            b_is_mem = 1'($urandom); bcst_rc = 1'($urandom);
            rc_global = 2'($urandom); rc_embed = 2'($urandom);
            run_and_check(1, 5'b0);
        end

        // rounding override: 0x3C01 squared lies between two neighbours
        for (int c = 0; c < 16; c++) begin
            src_a = '0; src_b = '0;
            src_a[15:0] = 16'h3C01; src_b[15:0] = 16'h3C01;
            vl_sel = 2'b10; mask_en = 0; zero_en = 0; b_is_mem = c[3];
            bcst_rc = 1; rc_embed = c[1:0]; rc_global = c[3:2] ^ 2'b01;
            run_and_check(1, 5'b0);
        end

        // sticky accumulation across back-to-back operations (no reset between)
        pulse_reset();
        vl_sel = 2'b00; mask_en = 0; zero_en = 0; b_is_mem = 0; bcst_rc = 0; rc_global = 2'b00;
        src_a = '0; src_b = '0;
        src_a[15:0] = 16'h3C01; src_b[15:0] = 16'h3C01;
        run_and_check(0, 5'b0);
        check("R11", "inexact after first op", 32'(exc_flags), 32'h01);
        src_a[15:0] = 16'h7D00; src_b[15:0] = 16'h3C00;
        run_and_check(0, 5'b00001);
        check("R11", "invalid joins inexact", 32'(exc_flags), 32'h11);
        // masked-off signalling NaN lane must add nothing
        mask_en = 1; mask = 32'hFFFF_FFFE; zero_en = 0;
        src_a[15:0] = 16'h7D00; src_a[31:16] = 16'h0001; src_b[31:16] = 16'h3C00;
        run_and_check(0, 5'b10001);
        check("R11", "masked lane adds no denormal", 32'(exc_flags), 32'h19);
        // idle cycle: nothing moves
        hold = dst;
        @(posedge clk); #1;
        check("R12", "out_valid low when idle", 32'(out_valid), 32'd0);
        check("R12", "dst held when idle", 32'(hold[31:0] ^ dst[31:0]), 32'd0);
        check("R11", "flags held when idle", 32'(exc_flags), 32'h19);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : watchdog
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule